// File: doc/BRIEF.md
# TDM Control-Signal Slave Demultiplexer

This block is the remote end of a time-multiplexed link that carries serial-port handshake lines over a few pins. It runs on the bit clock that the master sends, one bit per clock period. A frame has sixteen slots in each direction. The master pulls an active-low sync line for the single bit that is slot 15 of each frame. The block takes its slot alignment only from that pulse. It reports whether it is locked, which means the pulse keeps arriving where the slot count predicts.

Received bits are gathered into a sixteen-bit parallel word. That word is passed to the outputs only when a well-placed sync pulse closes a frame and leaves the block locked. At the same frame boundary, sixteen local inputs are captured and sent back one per slot on the return line.

Slot use on the forward path, bits 0 to 3: port-3 request-to-send, port-3 terminal-ready, port-1 request-to-send, port-2 request-to-send. Slot use on the return path, bits 0 to 3: port-3 clear-to-send, port-3 data-set-ready, port-3 carrier-detect, port-1 clear-to-send.

Top module: `tdm_ctrl_slave`

## Requirements
- R1: While reset is high and on the first cycle after it, `locked` is 0, `ctrl_out` is all zeros and `ser_out` is 0.
- R2: The bit sampled while `frm_sync_n` is low is treated as slot 15. The bit that follows it is slot 0, whatever the slot count was before.
- R3: `locked` rises at the clock edge that samples the second sync pulse in a row that falls exactly on the expected slot 15.
- R4: If `frm_sync_n` is high on the bit the count expects to be slot 15, `locked` is 0 from the next cycle on.
- R5: A sync pulse on any slot other than the expected slot 15 clears `locked` and realigns the count (R2). Two further well-placed frames are then needed to lock again.
- R6: At the edge of a well-placed sync that leaves the block locked, `ctrl_out[s]` takes the bit received in slot s of the frame just closed, for s = 0..15.
- R7: `ctrl_out` keeps its value across frames that end without a well-placed sync while locked.
- R8: During slot s, `ser_out` carries bit s of `ctrl_in` as sampled at the edge that closed the previous frame (the slot-15 edge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Received bit clock, one slot per period |
| rst | input | 1 | Synchronous active-high reset |
| frm_sync_n | input | 1 | Active-low frame sync, low during slot 15 |
| ser_in | input | 1 | Serial control bits from the master |
| ser_out | output | 1 | Serial status bits returned to the master |
| ctrl_in | input | 16 | Local status signals, bit s sent in slot s |
| ctrl_out | output | 16 | Latched control signals, bit s from slot s |
| locked | output | 1 | Frame alignment established |

## Verification
The bench drops a sync pulse. A design that kept lock there would go on passing words from a link with no alignment. The bench also moves the sync pulse to slot 7. A design that failed to realign would stay shifted by eight slots, and one that relocked after a single frame would pass a word that was never checked. Distinct data in every slot, including all-ones and all-zeros, exposes swapped or shifted bit order on both paths. Frames run while unlocked check that a design does not leak words to `ctrl_out` before lock is confirmed.

// File: rtl/tdm_ctrl_pkg.sv
package tdm_ctrl_pkg;

    localparam int NSLOTS_DEF      = 16;
    localparam int LOCK_FRAMES_DEF = 2;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_GOOD = 2'd1,
        EV_BAD  = 2'd2
    } sync_ev_e;

    typedef struct packed {
        logic frame_end;
        logic commit;
        logic locked;
    } trk_stat_t;

    // Classify what the sync line says about the current bit.
    function automatic sync_ev_e classify_sync(input logic sync_n, input logic at_last);
        sync_ev_e ev;
        if (!sync_n && at_last)       ev = EV_GOOD;
        else if (!sync_n || at_last)  ev = EV_BAD;
        else                          ev = EV_NONE;
        return ev;
    endfunction

endpackage

// File: rtl/tdm_slot_tracker.sv
module tdm_slot_tracker
    import tdm_ctrl_pkg::*;
#(
    parameter int NSLOTS      = NSLOTS_DEF,
    parameter int LOCK_FRAMES = LOCK_FRAMES_DEF,
    localparam int SW = $clog2(NSLOTS),
    localparam int CW = $clog2(LOCK_FRAMES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_n,
    output logic [SW-1:0] slot_q,
    output logic [SW-1:0] cur_slot,
    output trk_stat_t     stat
);

    localparam logic [SW-1:0] LAST    = SW'(NSLOTS - 1);
    localparam logic [CW-1:0] NEED    = CW'(LOCK_FRAMES);
    localparam logic [CW-1:0] NEED_M1 = CW'(LOCK_FRAMES - 1);

    logic [CW-1:0] good_q;
    logic          locked_q;
    sync_ev_e      ev;

    always_comb begin
        ev             = classify_sync(sync_n, slot_q == LAST);
        cur_slot       = sync_n ? slot_q : LAST;
        stat.frame_end = (cur_slot == LAST);
        stat.commit    = (ev == EV_GOOD) && (good_q >= NEED_M1);
        stat.locked    = locked_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= '0;
            good_q   <= '0;
            locked_q <= 1'b0;
        end else begin
            slot_q <= stat.frame_end ? '0 : SW'(cur_slot + 1'b1);
            case (ev)
                EV_GOOD: begin
                    if (good_q < NEED) good_q <= CW'(good_q + 1'b1);
                    locked_q <= (good_q >= NEED_M1);
                end
                EV_BAD: begin
                    good_q   <= '0;
                    locked_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
    parameter int NSLOTS = 16,
    localparam int SW = $clog2(NSLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_in,
    input  logic [SW-1:0]     cur_slot,
    input  logic              commit,
    output logic [NSLOTS-1:0] par_out
);

    logic [NSLOTS-1:0] sh_q;
    logic [NSLOTS-1:0] frame_v;

    for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                       sh_q[g] <= 1'b0;
            else if (cur_slot == SW'(g))   sh_q[g] <= ser_in;
        end
        assign frame_v[g] = (cur_slot == SW'(g)) ? ser_in : sh_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst)         par_out <= '0;
        else if (commit) par_out <= frame_v;
    end

endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser #(
    parameter int NSLOTS = 16,
    localparam int SW = $clog2(NSLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSLOTS-1:0] par_in,
    input  logic [SW-1:0]     cur_slot,
    input  logic              frame_end,
    output logic              ser_out
);

    logic [NSLOTS-1:0] hold_q;
    logic [SW-1:0]     nxt;

    assign nxt = SW'(cur_slot + 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            ser_out <= 1'b0;
        end else if (frame_end) begin
            hold_q  <= par_in;
            ser_out <= par_in[0];
        end else begin
            ser_out <= hold_q[nxt];
        end
    end

endmodule

// File: rtl/tdm_ctrl_slave.sv
module tdm_ctrl_slave
    import tdm_ctrl_pkg::*;
#(
    parameter int NSLOTS      = NSLOTS_DEF,
    parameter int LOCK_FRAMES = LOCK_FRAMES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_sync_n,
    input  logic              ser_in,
    output logic              ser_out,
    input  logic [NSLOTS-1:0] ctrl_in,
    output logic [NSLOTS-1:0] ctrl_out,
    output logic              locked
);

    localparam int SW = $clog2(NSLOTS);

    logic [SW-1:0] trk_slot;
    logic [SW-1:0] cur_slot;
    trk_stat_t     stat;

    tdm_slot_tracker #(.NSLOTS(NSLOTS), .LOCK_FRAMES(LOCK_FRAMES)) trk_i (
        .clk      (clk),
        .rst      (rst),
        .sync_n   (frm_sync_n),
        .slot_q   (trk_slot),
        .cur_slot (cur_slot),
        .stat     (stat)
    );

    tdm_rx_deser #(.NSLOTS(NSLOTS)) rx_i (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .cur_slot (cur_slot),
        .commit   (stat.commit),
        .par_out  (ctrl_out)
    );

    tdm_tx_ser #(.NSLOTS(NSLOTS)) tx_i (
        .clk       (clk),
        .rst       (rst),
        .par_in    (ctrl_in),
        .cur_slot  (cur_slot),
        .frame_end (stat.frame_end),
        .ser_out   (ser_out)
    );

    assign locked = stat.locked;

endmodule

// File: rtl/tdm_ctrl_slave_chk.sv
module tdm_ctrl_slave_chk #(
    parameter int NSLOTS = 16,
    localparam int SW = $clog2(NSLOTS)
) (
    input logic              clk,
    input logic              rst,
    input logic              frm_sync_n,
    input logic              ser_out,
    input logic [NSLOTS-1:0] ctrl_in,
    input logic [NSLOTS-1:0] ctrl_out,
    input logic              locked,
    input logic [SW-1:0]     slot_q
);

    localparam logic [SW-1:0] LAST = SW'(NSLOTS - 1);

    // R3
    lock_rise_on_sync_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(!frm_sync_n));

    // R4
    missing_sync_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_sync_n && slot_q == LAST) |=> !locked);

    // R5
    stray_sync_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        (!frm_sync_n && slot_q != LAST) |=> !locked);

    // R2
    realign_chk: assert property (@(posedge clk) disable iff (rst)
        !frm_sync_n |=> slot_q == '0);

    // R7
    out_change_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_out) |-> (locked && $past(!frm_sync_n)));

    // R8
    tx_slot0_chk: assert property (@(posedge clk) disable iff (rst)
        !frm_sync_n |=> ser_out == $past(ctrl_in[0]));

endmodule

bind tdm_ctrl_slave tdm_ctrl_slave_chk #(.NSLOTS(NSLOTS)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .frm_sync_n (frm_sync_n),
    .ser_out    (ser_out),
    .ctrl_in    (ctrl_in),
    .ctrl_out   (ctrl_out),
    .locked     (locked),
    .slot_q     (trk_slot)
);

// File: tb/tdm_ctrl_slave_tb.sv
module tdm_ctrl_slave_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_sync_n = 1'b1;
    logic        ser_in = 1'b0;
    logic        ser_out;
    logic [15:0] ctrl_in = '0;
    logic [15:0] ctrl_out;
    logic        locked;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        logic        lk;
        logic [15:0] val;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [15:0] tx_exp = '0;

    always #4 clk = ~clk;

    tdm_ctrl_slave dut_i (
        .clk(clk), .rst(rst), .frm_sync_n(frm_sync_n), .ser_in(ser_in),
        .ser_out(ser_out), .ctrl_in(ctrl_in), .ctrl_out(ctrl_out), .locked(locked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare frame results as the design produces them
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            chk({it.tag, " locked"}, {31'd0, locked}, {31'd0, it.lk});
            chk({it.tag, " ctrl_out"}, {16'd0, ctrl_out}, {16'd0, it.val});
        end
    end

    // Driver: one frame; sync_at < 0 means no sync pulse
    task automatic frame(input logic [15:0] data, input int sync_at, input logic [15:0] pin,
                         input bit check_tx, input logic exp_lk, input logic [15:0] exp_out,
                         input string tag);
        for (int s = 0; s < 16; s++) begin
            @(negedge clk);
            if (s == 0) begin
                rst     = 1'b0;
                ctrl_in = pin;
            end
            ser_in     = data[s];
            frm_sync_n = (s == sync_at) ? 1'b0 : 1'b1;
            if (check_tx) chk("R8 ser_out slot", {31'd0, ser_out}, {31'd0, tx_exp[s]});
        end
        @(posedge clk);
        exp_q.push_back('{exp_lk, exp_out, tag});
        tx_exp = pin;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset locked", {31'd0, locked}, 32'd0);
        chk("R1 reset ctrl_out", {16'd0, ctrl_out}, 32'd0);
        chk("R1 reset ser_out", {31'd0, ser_out}, 32'd0);

        frame(16'hA5C3, 15, 16'h1234, 1, 1'b0, 16'h0000, "R3 first frame");
        frame(16'h8001, 15, 16'hF00F, 1, 1'b1, 16'h8001, "R3 R6 lock");
        frame(16'h3C96, 15, 16'h5AA5, 1, 1'b1, 16'h3C96, "R6 pattern");
        frame(16'h7E7E, -1, 16'h0F0F, 1, 1'b0, 16'h3C96, "R4 R7 no sync");
        frame(16'h1111, 15, 16'h8421, 1, 1'b0, 16'h3C96, "R7 relock 1");
        frame(16'hC0DE, 15, 16'hFFFF, 1, 1'b1, 16'hC0DE, "R3 R6 relock");
        frame(16'h2222, 7, 16'h1357, 0, 1'b0, 16'hC0DE, "R5 stray sync");
        frame(16'h4444, 15, 16'h2468, 0, 1'b0, 16'hC0DE, "R2 R5 realign");
        frame(16'h5555, 15, 16'h0001, 1, 1'b0, 16'hC0DE, "R5 R7 after realign");
        frame(16'hBEEF, 15, 16'h8000, 1, 1'b1, 16'hBEEF, "R2 R5 R6 relocked");
        frame(16'hFFFF, 15, 16'h0000, 1, 1'b1, 16'hFFFF, "R6 all ones");
        frame(16'h0000, 15, 16'hAAAA, 1, 1'b1, 16'h0000, "R6 all zeros");
        frame(16'h0000, 15, 16'h0000, 1, 1'b1, 16'h0000, "R8 final");
        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule